// File: doc/BRIEF.md
# PLL Unlock Detector with Stretch

This block decides whether a phase-locked loop has lost lock by looking at the phase-error pulses from the phase comparator. A 2-bit mode input selects one of four behaviours. Detection can be switched off. The raw error can be forwarded to the unlock output unchanged. In the other two modes, the block times each continuous error pulse against a short or a long width limit. When a pulse runs past the selected limit, the unlock indication is held for a millisecond-scale window. This lets a slowly polled status line still catch a brief loss of lock.

All widths come from a clock-frequency parameter. The pulse limits are given in nanoseconds and rounded to the nearest cycle count. The hold window is given in microseconds. With the defaults (10 MHz clock, 550 ns, 1110 ns, 1500 µs), the limits are 6 and 11 cycles and the window is 15000 cycles. Two outputs report the result. `unlock_o` is high when the status line should be pulled low. `locked_o` is the read-back status bit, where 1 means locked.

Top module: `pll_unlock_watch`

## Requirements
- R1: After reset, `unlock_o` is 0 and `locked_o` is 1.
- R2: In mode `det_mode = 2'b00`, `unlock_o` stays 0 whatever `phase_err` does, and no hold window is started.
- R3: In mode `2'b01`, `unlock_o` follows `phase_err` combinationally in the same cycle.
- R4: In mode `2'b10`, a `phase_err` pulse high for up to THR_N (default 6) consecutive clock edges gives no unlock. On the edge that samples it high for the THR_N+1-th time in a row, `unlock_o` rises.
- R5: In mode `2'b11`, the same rule applies with THR_W (default 11) consecutive edges, so a 12-edge pulse gives unlock and an 11-edge pulse does not.
- R6: Once `phase_err` is low again, `unlock_o` stays 1 for exactly STRETCH_CYC (default 15000) clock edges, counted from the last over-limit edge, and then falls.
- R7: An over-limit edge while a hold window is active restarts the window at its full length.
- R8: A low `phase_err` sample clears the width count, so shorter pulses separated by gaps never add up to an over-limit pulse.
- R9: Any change of `det_mode` clears the hold window and the width count at the next clock edge.
- R10: `locked_o` is always the inverse of `unlock_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_err | input | 1 | Phase-error pulse from the comparator |
| det_mode | input | 2 | 00 off, 01 pass-through, 10 short limit, 11 long limit |
| unlock_o | output | 1 | 1 = unlocked, status line to be pulled low |
| locked_o | output | 1 | Status bit, 1 = locked |

## Verification
The bench puts pulses exactly one edge below and one edge above each limit. A design off by one in its width compare would raise unlock early or miss it. It measures the hold window to the exact cycle, retriggers partway through, and holds the error high for a long run. A window that is not reloaded, or that is counted from the first over-limit edge instead of the last, would then end too soon. It also separates two pulses that are each under the limit by a single low cycle, which exposes a width count that does not clear on a gap. Finally, it switches mode in the middle of a window to confirm that the window is cleared.

// File: rtl/pll_unlock_watch.sv
module pll_unlock_watch #(
  parameter int CLK_HZ     = 10_000_000,
  parameter int NARROW_NS  = 550,
  parameter int WIDE_NS    = 1110,
  parameter int STRETCH_US = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_err,
  input  logic [1:0] det_mode,
  output logic       unlock_o,
  output logic       locked_o
);

  localparam int KHZ         = CLK_HZ / 1000;
  localparam int THR_N       = (KHZ * NARROW_NS + 500_000) / 1_000_000;
  localparam int THR_W       = (KHZ * WIDE_NS + 500_000) / 1_000_000;
  localparam int STRETCH_CYC = KHZ * STRETCH_US / 1000;
  localparam int WW          = $clog2(THR_W + 1);
  localparam int SW          = $clog2(STRETCH_CYC + 1);

  logic [1:0]    mode_q;
  logic [WW-1:0] wcnt;
  logic [SW-1:0] scnt;
  logic [WW-1:0] thr_sel;
  logic          thresh_mode, mode_moved, over;

  assign thresh_mode = det_mode[1];
  assign mode_moved  = det_mode != mode_q;
  assign thr_sel     = det_mode[0] ? WW'(THR_W) : WW'(THR_N);
  assign over        = thresh_mode && !mode_moved && phase_err && (wcnt >= thr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00;
      wcnt   <= '0;
      scnt   <= '0;
    end else begin
      mode_q <= det_mode;
      if (mode_moved || !phase_err)
        wcnt <= '0;
      else if (wcnt < WW'(THR_W))
        wcnt <= wcnt + WW'(1);
      if (mode_moved || !thresh_mode)
        scnt <= '0;
      else if (over)
        scnt <= SW'(STRETCH_CYC);
      else if (scnt != '0)
        scnt <= scnt - SW'(1);
    end
  end

  always_comb begin
    case (det_mode)
      2'b00:   unlock_o = 1'b0;
      2'b01:   unlock_o = phase_err;
      default: unlock_o = (scnt != '0);
    endcase
  end

  assign locked_o = !unlock_o;

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00 && det_mode == 2'b00) |-> (scnt == '0));

  assert_rise_needs_err_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(scnt != '0) |-> ($past(phase_err) && $past(det_mode[1])));

  assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (scnt != '0 && !phase_err && det_mode == mode_q) |=> (scnt == $past(scnt) - SW'(1)));

  assert_gap_resets_R8: assert property (@(posedge clk) disable iff (rst)
    !phase_err |=> (wcnt == '0));

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (det_mode != mode_q) |=> (scnt == '0 && wcnt == '0));

endmodule

// File: tb/test_pll_unlock_watch.sv
module test_pll_unlock_watch;
  localparam int THR_N = 6;
  localparam int THR_W = 11;
  localparam int S     = 15000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_err = 1'b0;
  logic [1:0] det_mode = 2'b00;
  logic unlock_o, locked_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pll_unlock_watch i_pll_unlock_watch (
    .clk(clk), .rst(rst), .phase_err(phase_err), .det_mode(det_mode),
    .unlock_o(unlock_o), .locked_o(locked_o));

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
    if (locked_o !== !unlock_o) begin
      errors++;
      $display("FAIL R10: locked_o %b unlock_o %b", locked_o, unlock_o);
    end
  endtask

  task automatic pulse(input int n);
    phase_err = 1'b1;
    repeat (n) @(negedge clk);
    phase_err = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    det_mode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_window(input string req);
    repeat (S - 1) @(negedge clk);
    check(unlock_o, 1'b1, req);
    @(negedge clk);
    check(unlock_o, 1'b0, req);
  endtask

  task automatic t_reset;
    check(unlock_o, 1'b0, "R1");
    check(locked_o, 1'b1, "R1");
  endtask

  task automatic t_stopped;
    set_mode(2'b00);
    phase_err = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check(unlock_o, 1'b0, "R2");
    end
    phase_err = 1'b0;
    @(negedge clk);
    check(unlock_o, 1'b0, "R2");
  endtask

  task automatic t_pass;
    set_mode(2'b01);
    for (int i = 0; i < 6; i++) begin
      phase_err = i[0];
      #1;
      check(unlock_o, i[0], "R3");
      @(negedge clk);
    end
    phase_err = 1'b0;
  endtask

  task automatic t_narrow;
    set_mode(2'b10);
    pulse(THR_N);
    check(unlock_o, 1'b0, "R4 at limit");
    @(negedge clk);
    pulse(THR_N + 1);
    check(unlock_o, 1'b1, "R4 over limit");
    wait_window("R6");
  endtask

  task automatic t_gap;
    set_mode(2'b10);
    pulse(THR_N);
    @(negedge clk);
    pulse(THR_N);
    check(unlock_o, 1'b0, "R8");
    repeat (4) @(negedge clk);
    check(unlock_o, 1'b0, "R8");
  endtask

  task automatic t_wide;
    set_mode(2'b11);
    pulse(THR_W);
    check(unlock_o, 1'b0, "R5 at limit");
    @(negedge clk);
    pulse(THR_W + 1);
    check(unlock_o, 1'b1, "R5 over limit");
    wait_window("R5 window");
  endtask

  task automatic t_retrigger;
    set_mode(2'b10);
    pulse(THR_N + 1);
    repeat (5000) @(negedge clk);
    check(unlock_o, 1'b1, "R7 mid window");
    pulse(THR_N + 1);
    wait_window("R7");
  endtask

  task automatic t_long_hold;
    set_mode(2'b11);
    pulse(40);
    check(unlock_o, 1'b1, "R7 held error");
    wait_window("R7 held error");
  endtask

  task automatic t_mode_change;
    set_mode(2'b10);
    pulse(THR_N + 1);
    repeat (10) @(negedge clk);
    check(unlock_o, 1'b1, "R9 before");
    det_mode = 2'b11;
    @(negedge clk);
    check(unlock_o, 1'b0, "R9 after");
    repeat (20) @(negedge clk);
    check(unlock_o, 1'b0, "R9 stays clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_stopped;
    t_pass;
    t_narrow;
    t_gap;
    t_wide;
    t_retrigger;
    t_long_hold;
    t_mode_change;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule